// File: doc/BRIEF.md
# Zero-Crossing Clamp Sequencer for an Eight-Switch Multilevel Inverter

This block sits between the modulator and the gate drivers of an eight-switch asymmetric multilevel inverter. In normal operation it forwards the modulator's gate vector unchanged. When the modulation wave crosses zero, the left arm and the right arm change state. If both arms switched together, any skew between them, or the dead time inside the right-arm complementary pair, would let the output jump briefly to the full positive or negative rail. The block prevents this by taking over the gates for a short, fixed sequence.

For each crossing event the block runs three phases and then hands control back. First it turns on a set of three clamp switches while the right-arm switch that was conducting stays on. Next it turns off everything except the clamp switches, so the output is held at one third of the rail while both right-arm switches are off. This phase lasts a programmable number of clock cycles. Last, it turns on the opposite right-arm switch for one cycle, and then the normal vector is used again. The sequence is timed only. No current is sensed.

Top module: `zc_clamp_seq`

## Requirements
- R1: While no sequence is running, `gate_out` equals `gate_nom` in the same cycle and `busy` is 0. Bit i of a gate vector drives switch V(i+1): bit 0 is V1 and bit 7 is V8.
- R2: A `zc_event` sampled high at a clock edge while idle starts a sequence. In the first cycle after that edge, `gate_out` is the clamp set plus the old right-arm switch. For `zc_dir`=0 (rising crossing) this is 8'h5C: V3, V4, V5 and V7.
- R3: After that first cycle comes the dead phase, which lasts D cycles. During it `gate_out` is the clamp set alone, with V7 and V8 both off: 8'h1C for `zc_dir`=0 and 8'h23 for `zc_dir`=1. D is the `dead_cnt` value captured with the event.
- R4: A captured `dead_cnt` of 0 gives a dead phase of exactly 1 cycle.
- R5: After the dead phase, `gate_out` is the clamp set plus the new right-arm switch for one cycle (8'h9C for `zc_dir`=0). In the following cycle the block is idle again and passes `gate_nom` through.
- R6: For `zc_dir`=1 (falling crossing) the sequence is mirrored. The clamp set is V1, V2 and V6, the old right-arm switch is V8 and the new one is V7. The three phases are therefore 8'hA3, 8'h23 and 8'h63.
- R7: A `zc_event` that arrives while a sequence is running is ignored. The running sequence keeps its direction, its outputs and its length, and no second sequence follows it.
- R8: `busy` is 1 for exactly D+2 cycles per sequence, starting in the cycle after the event edge.
- R9: While reset is asserted, the block is idle: `busy` is 0 and `gate_out` equals `gate_nom`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| zc_event | input | 1 | Zero-crossing event, sampled at the clock edge |
| zc_dir | input | 1 | Crossing direction: 0 for the rising crossing, 1 for the falling crossing |
| dead_cnt | input | DW | Length of the dead phase in cycles (0 is treated as 1) |
| gate_nom | input | 8 | Normal gate vector from the modulator |
| gate_out | output | 8 | Gate vector sent to the switches |
| busy | output | 1 | High while a clamp sequence is running |

## Verification
The first phase of a sequence appears one cycle after the edge that samples the event. The dead phase occupies cycles 2 to D+1 and the closing phase falls on cycle D+2. On cycle D+3 the block is idle and passes `gate_nom` through again, in the same cycle as the input. The bench raises the event at a falling edge and then checks `gate_out` and `busy` at every following falling edge, with the cycle index j counted from the event edge. It compares against a phase table worked out from j, the direction and the saturated dead count. Late events are injected at cycle 1 and at cycle D+2 to show that they change none of these values.

// File: rtl/zc_pkg.sv
package zc_pkg;
  localparam int NSW = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MAKE,
    ST_DEAD,
    ST_NEW
  } seq_st_e;

  // bit i drives switch V(i+1)
  localparam logic [NSW-1:0] SW_V7     = 8'h40;
  localparam logic [NSW-1:0] SW_V8     = 8'h80;
  localparam logic [NSW-1:0] CLAMP_POS = 8'h1C; // V3 V4 V5
  localparam logic [NSW-1:0] CLAMP_NEG = 8'h23; // V1 V2 V6
endpackage

// File: rtl/zc_rst_sync.sv
module zc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/zc_mask_sel.sv
module zc_mask_sel
  import zc_pkg::*;
(
  input  logic           dir,
  output logic [NSW-1:0] clamp,
  output logic [NSW-1:0] old_r,
  output logic [NSW-1:0] new_r
);
  always_comb begin
    if (dir) begin
      clamp = CLAMP_NEG;
      old_r = SW_V8;
      new_r = SW_V7;
    end else begin
      clamp = CLAMP_POS;
      old_r = SW_V7;
      new_r = SW_V8;
    end
  end
endmodule

// File: rtl/zc_dead_timer.sv
module zc_dead_timer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          dec,
  input  logic [DW-1:0] load_val,
  output logic          last
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = cnt_q;
    if (load)     cnt_d = (load_val == '0) ? ONE : load_val;
    else if (dec) cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= ONE;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == ONE);
endmodule

// File: rtl/zc_clamp_seq.sv
module zc_clamp_seq
  import zc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           zc_event,
  input  logic           zc_dir,
  input  logic [DW-1:0]  dead_cnt,
  input  logic [NSW-1:0] gate_nom,
  output logic [NSW-1:0] gate_out,
  output logic           busy
);
  seq_st_e        st_q, st_d;
  logic           dir_q, dir_d, dir_en;
  logic           tmr_load, tmr_dec, tmr_last;
  logic           rst_n_i;
  logic [NSW-1:0] m_clamp, m_old, m_new;

  zc_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  zc_mask_sel i_mask_sel (
    .dir   (dir_q),
    .clamp (m_clamp),
    .old_r (m_old),
    .new_r (m_new)
  );

  zc_dead_timer #(.DW(DW)) i_dead_timer (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (tmr_load),
    .dec      (tmr_dec),
    .load_val (dead_cnt),
    .last     (tmr_last)
  );

  // next-state process
  always_comb begin
    st_d     = st_q;
    dir_d    = dir_q;
    dir_en   = 1'b0;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    case (st_q)
      ST_IDLE: if (zc_event) begin
        st_d     = ST_MAKE;
        dir_d    = zc_dir;
        dir_en   = 1'b1;
        tmr_load = 1'b1;
      end
      ST_MAKE: st_d = ST_DEAD;
      ST_DEAD: begin
        tmr_dec = 1'b1;
        if (tmr_last) st_d = ST_NEW;
      end
      ST_NEW:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q  <= ST_IDLE;
      dir_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (dir_en) dir_q <= dir_d;
    end
  end

  // output selection
  always_comb begin
    case (st_q)
      ST_MAKE: gate_out = m_clamp | m_old;
      ST_DEAD: gate_out = m_clamp;
      ST_NEW:  gate_out = m_clamp | m_new;
      default: gate_out = gate_nom;
    endcase
  end

  assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/zc_clamp_chk.sv
module zc_clamp_chk
  import zc_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic [NSW-1:0] gate_nom,
  input logic [NSW-1:0] gate_out,
  input logic           busy,
  input seq_st_e        st
);
  // R1
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> gate_out == gate_nom);

  // R3
  dead_pair_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_DEAD |-> gate_out[7:6] == 2'b00);

  // R2
  make_to_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_MAKE |=> st == ST_DEAD);

  // R6
  clamp_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(gate_out[5:0]) == 3 && $onehot0(gate_out[7:6])));

  // R5
  end_after_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(st) == ST_NEW);
endmodule

bind zc_clamp_seq zc_clamp_chk i_zc_clamp_chk (
  .clk      (clk),
  .rst_n    (rst_n_i),
  .gate_nom (gate_nom),
  .gate_out (gate_out),
  .busy     (busy),
  .st       (st_q)
);

// File: tb/test_zc_clamp_seq.sv
module test_zc_clamp_seq;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic          zc_event;
  logic          zc_dir;
  logic [DW-1:0] dead_cnt;
  logic [7:0]    gate_nom;
  logic [7:0]    gate_out;
  logic          busy;

  int n_chk;
  int n_err;
  bit done;

  zc_clamp_seq #(.DW(DW)) i_zc_clamp_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .zc_event (zc_event),
    .zc_dir   (zc_dir),
    .dead_cnt (dead_cnt),
    .gate_nom (gate_nom),
    .gate_out (gate_out),
    .busy     (busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got busy/gate=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // expected {busy, gate} at cycle j after the event edge
  function automatic logic [8:0] exp_at(input logic dir, input int d, input int j,
                                        input logic [7:0] nom);
    logic [7:0] cl, o, n;
    cl = dir ? 8'h23 : 8'h1C;
    o  = dir ? 8'h80 : 8'h40;
    n  = dir ? 8'h40 : 8'h80;
    if (j == 1)          return {1'b1, cl | o};
    else if (j <= d + 1) return {1'b1, cl};
    else if (j == d + 2) return {1'b1, cl | n};
    else                 return {1'b0, nom};
  endfunction

  task automatic run_seq(input logic dir, input int dead, input logic [7:0] nom,
                         input bit inject);
    int d;
    string tag;
    d = (dead == 0) ? 1 : dead;
    @(negedge clk);
    zc_dir   = dir;
    dead_cnt = DW'(dead);
    gate_nom = nom;
    zc_event = 1'b1;
    for (int j = 1; j <= d + 3; j++) begin
      @(negedge clk);
      zc_event = 1'b0;
      zc_dir   = ~dir;
      if (j == 1)          tag = dir ? "R6/R2 make" : "R2 make";
      else if (j <= d + 1) tag = (dead == 0) ? "R4 dead" : (dir ? "R6/R3 dead" : "R3 dead");
      else if (j == d + 2) tag = dir ? "R6/R5 new" : "R5 new";
      else                 tag = "R8/R1 release";
      if (inject) tag = {tag, " R7"};
      chk(tag, {busy, gate_out}, exp_at(dir, d, j, gate_nom));
      if (inject && (j == 1 || j == d + 2)) begin
        zc_event = 1'b1;
        gate_nom = ~nom;
      end
    end
    // no restart after an ignored event
    @(negedge clk);
    chk("R7 no restart", {busy, gate_out}, {1'b0, gate_nom});
  endtask

  initial begin
    done     = 1'b0;
    n_chk    = 0;
    n_err    = 0;
    rst_n    = 1'b0;
    zc_event = 1'b0;
    zc_dir   = 1'b0;
    dead_cnt = '0;
    gate_nom = 8'h47;
    repeat (3) @(negedge clk);
    chk("R9 reset", {busy, gate_out}, {1'b0, 8'h47});
    gate_nom = 8'hB8;
    #1;
    chk("R9 reset pass", {busy, gate_out}, {1'b0, 8'hB8});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int p = 0; p < 8; p++) begin
      gate_nom = 8'(p * 37 + 5);
      #1;
      chk("R1 idle", {busy, gate_out}, {1'b0, gate_nom});
    end
    for (int dir = 0; dir < 2; dir++)
      for (int dead = 0; dead < 7; dead++)
        for (int inj = 0; inj < 2; inj++)
          run_seq(1'(dir), dead, 8'(dead * 29 + dir * 64 + 3), 1'(inj));
    run_seq(1'b0, 20, 8'h47, 1'b1);
    run_seq(1'b1, 20, 8'hB8, 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule